// File: doc/BRIEF.md
# Windowed Watchdog Timer with Write-Guarded Control

This block is a watchdog timer with a small register port. Software keeps the system alive by feeding the counter. A feed is a pair of writes to the feed register: a first key, then a second key. The counter runs only while both its clock enable and its timer enable are set. It compares its count against three thresholds. Each threshold is chosen by a period code and equals 2^(TOP_EXP - code) counter clocks. The timeout threshold raises a timeout event. The reset threshold asks the system for a reset. The wait threshold opens the service window: a feed that arrives before the count reaches it is an early feed, and the block records it.

The control register is guarded by a lock. It accepts writes only after the unlock key has been written to the lock register. Events are kept in a write-one-to-clear flag register. A per-event arm register decides which flags drive the interrupt line, and whether the reset threshold produces a reset request. The register port is plain control. There is no stream interface, so no valid/ready back-pressure applies: a write is taken on every clock edge where `reg_wr` is high, and `reg_rdata` follows `reg_addr` combinationally.

Top module: `windowed_wdog`

## Requirements
- R1: After reset the lock register reads 1, the control, arm and flag registers read 0, `irq` is 0 and `rst_req` is 0.
- R2: Writing 32'h000000C3 to the lock register (address 3) makes its bit 0 read 0. Writing 32'h0000003C makes it read 1. Any other value leaves it unchanged.
- R3: The control register (address 0) holds clk_en in bit 0, tmr_en in bit 1, the timeout code in bits 7:4, the wait code in bits 11:8 and the reset code in bits 15:12. Bits 3:2 and 31:16 read 0. While the lock bit is 1, writes to it are ignored.
- R4: A control write in which any of the three codes is PERIOD_MAX or larger is ignored as a whole.
- R5: The counter advances by one per clock only while clk_en and tmr_en are both 1. Otherwise it holds, and no threshold event occurs.
- R6: Flag bit 0 (timeout) sets on the edge where the count, counted since the last feed, reaches 2^(TOP_EXP - timeout code).
- R7: A feed happens when 32'h000000A5 and then 32'h0000005A are written to the feed register (address 2) as two consecutive writes. A feed puts the count back to 0. Any write between the two keys aborts the sequence. The feed register reads 0.
- R8: A feed that arrives while the count is below 2^(TOP_EXP - wait code) sets flag bit 1 (early feed).
- R9: When the count reaches 2^(TOP_EXP - reset code) while arm bit 2 is 1, `rst_req` is high for exactly one cycle and flag bit 2 sets. With arm bit 2 at 0, neither happens.
- R10: Writing ones to the flag register (address 4) clears those bits. If an event sets a bit on the same edge, the set wins.
- R11: `irq` is high exactly when some flag bit is set and its arm bit (address 1, bits 2:0) is also set. Writing 0 to the arm register masks every output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Watchdog clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, one write per cycle |
| reg_addr | input | AW | Register address |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for `reg_addr` |
| irq | output | 1 | Masked OR of the event flags |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The sharpest collision is a write-one-to-clear on the flag register that lands on the same edge as the timeout threshold. The bench feeds the counter, counts the exact number of cycles to the threshold, and places the clear write on that edge. The write must clear the other flags while the timeout flag survives. A feed landing inside an abort sequence, or right on a threshold, is also provoked by the random phase. There, a cycle-level model built from the requirements judges `irq`, `rst_req` and every read on every cycle.

// File: rtl/wdw_pkg.sv
package wdw_pkg;
  localparam int SEL_W = 4;
  localparam int EV_N  = 3;

  localparam int EV_TO    = 0;
  localparam int EV_EARLY = 1;
  localparam int EV_RST   = 2;

  localparam int unsigned A_CTRL = 0;
  localparam int unsigned A_ARM  = 1;
  localparam int unsigned A_FEED = 2;
  localparam int unsigned A_LOCK = 3;
  localparam int unsigned A_FLAG = 4;

  localparam logic [31:0] K_UNLOCK = 32'h0000_00C3;
  localparam logic [31:0] K_LOCK   = 32'h0000_003C;
  localparam logic [31:0] K_FEED1  = 32'h0000_00A5;
  localparam logic [31:0] K_FEED2  = 32'h0000_005A;

  typedef struct packed {
    logic [SEL_W-1:0] rst_sel;
    logic [SEL_W-1:0] wait_sel;
    logic [SEL_W-1:0] to_sel;
    logic [1:0]       spare;
    logic             tmr_en;
    logic             clk_en;
  } ctrl_t;
endpackage

// File: rtl/wdw_cfg.sv
module wdw_cfg
  import wdw_pkg::*;
#(
  parameter int DW         = 32,
  parameter int AW         = 3,
  parameter int PERIOD_MAX = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          locked,
  output ctrl_t         ctrl,
  output logic [EV_N-1:0] arm
);
  localparam logic [SEL_W-1:0] SEL_TOP = SEL_W'(PERIOD_MAX - 1);

  logic  wr_lock, wr_ctrl, wr_arm, codes_ok;
  ctrl_t wctrl;

  assign wr_lock = wr && (addr == AW'(A_LOCK));
  assign wr_ctrl = wr && (addr == AW'(A_CTRL));
  assign wr_arm  = wr && (addr == AW'(A_ARM));
  assign wctrl   = wdata[$bits(ctrl_t)-1:0];
  assign codes_ok = (wctrl.to_sel <= SEL_TOP) && (wctrl.wait_sel <= SEL_TOP) &&
                    (wctrl.rst_sel <= SEL_TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b1;
    end else if (wr_lock && wdata == DW'(K_UNLOCK)) begin
      locked <= 1'b0;
    end else if (wr_lock && wdata == DW'(K_LOCK)) begin
      locked <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (wr_ctrl && !locked && codes_ok) begin
      ctrl       <= wctrl;
      ctrl.spare <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arm <= '0;
    else if (wr_arm) arm <= wdata[EV_N-1:0];
  end

  p_locked_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(ctrl));
  p_bad_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && wdata[7:4] > SEL_TOP) |=> $stable(ctrl));
endmodule

// File: rtl/wdw_feed.sv
module wdw_feed
  import wdw_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          feed
);
  logic to_feed, armed_q;

  assign to_feed = wr && (addr == AW'(A_FEED));
  assign feed    = to_feed && (wdata == DW'(K_FEED2)) && armed_q;

  // Any write re-decides the armed state, so only back-to-back keys pass.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else if (wr) armed_q <= to_feed && (wdata == DW'(K_FEED1));
  end

  p_feed_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    feed |=> !feed);
endmodule

// File: rtl/wdw_core.sv
module wdw_core
  import wdw_pkg::*;
#(
  parameter int TOP_EXP = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] to_sel,
  input  logic [SEL_W-1:0] wait_sel,
  input  logic [SEL_W-1:0] rst_sel,
  input  logic [EV_N-1:0]  arm,
  input  logic             feed,
  input  logic [EV_N-1:0]  flag_clr,
  output logic [EV_N-1:0]  flags,
  output logic             irq,
  output logic             rst_req
);
  localparam int CW = TOP_EXP + 1;

  function automatic logic [CW-1:0] thr_of(input logic [SEL_W-1:0] code);
    return CW'(1) << (TOP_EXP - int'(code));
  endfunction

  logic [CW-1:0]   cnt_q, cnt_inc, thr_to, thr_wait, thr_rst;
  logic            step;
  logic [EV_N-1:0] ev;

  assign thr_to   = thr_of(to_sel);
  assign thr_wait = thr_of(wait_sel);
  assign thr_rst  = thr_of(rst_sel);
  assign cnt_inc  = cnt_q + 1'b1;
  assign step     = run && !feed && !(&cnt_q);

  assign ev[EV_TO]    = step && (cnt_inc == thr_to);
  assign ev[EV_EARLY] = feed && (cnt_q < thr_wait);
  assign ev[EV_RST]   = step && (cnt_inc == thr_rst) && arm[EV_RST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      flags   <= '0;
      rst_req <= 1'b0;
    end else begin
      if (feed) cnt_q <= '0;
      else if (step) cnt_q <= cnt_inc;
      flags   <= (flags & ~flag_clr) | ev;
      rst_req <= ev[EV_RST];
    end
  end

  assign irq = |(flags & arm);

  p_feed_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    feed |=> (cnt_q == '0));
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !feed) |=> $stable(cnt_q));
  p_rst_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  p_rst_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> flags[EV_RST]);
  p_w1c_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((&flag_clr) && !(|ev)) |=> (flags == '0));
endmodule

// File: rtl/windowed_wdog.sv
module windowed_wdog
  import wdw_pkg::*;
#(
  parameter int DW         = 32,
  parameter int AW         = 3,
  parameter int TOP_EXP    = 31,
  parameter int PERIOD_MAX = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq,
  output logic          rst_req
);
  logic            locked, feed;
  ctrl_t           ctrl;
  logic [EV_N-1:0] arm, flags, flag_clr;

  assign flag_clr = (reg_wr && reg_addr == AW'(A_FLAG)) ? reg_wdata[EV_N-1:0] : '0;

  wdw_cfg #(.DW(DW), .AW(AW), .PERIOD_MAX(PERIOD_MAX)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .locked(locked), .ctrl(ctrl), .arm(arm));

  wdw_feed #(.DW(DW), .AW(AW)) u_feed (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .feed(feed));

  wdw_core #(.TOP_EXP(TOP_EXP)) u_core (
    .clk(clk), .rst_n(rst_n), .run(ctrl.clk_en && ctrl.tmr_en),
    .to_sel(ctrl.to_sel), .wait_sel(ctrl.wait_sel), .rst_sel(ctrl.rst_sel),
    .arm(arm), .feed(feed), .flag_clr(flag_clr),
    .flags(flags), .irq(irq), .rst_req(rst_req));

  always_comb begin
    case (reg_addr)
      AW'(A_CTRL): reg_rdata = DW'(ctrl);
      AW'(A_ARM):  reg_rdata = DW'(arm);
      AW'(A_LOCK): reg_rdata = DW'(locked);
      AW'(A_FLAG): reg_rdata = DW'(flags);
      default:     reg_rdata = '0;
    endcase
  end
endmodule

// File: tb/windowed_wdog_bench.sv
`timescale 1ns/100ps
module windowed_wdog_bench;
  localparam int TE = 12;
  localparam int PM = 10;
  localparam int CMAX = (1 << (TE + 1)) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, rst_req;

  int n_cmp = 0, n_bad = 0;
  bit cmp_on = 0, done = 0;

  always #2 clk = ~clk;

  windowed_wdog #(.DW(32), .AW(3), .TOP_EXP(TE), .PERIOD_MAX(PM)) u_windowed_wdog (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .rst_req(rst_req));

  // Reference model built from the requirements
  bit m_locked, m_armed, m_rst;
  logic [15:0] m_ctrl;
  logic [2:0]  m_en, m_flags;
  int m_cnt;

  function automatic int thr(input logic [3:0] c);
    return 1 << (TE - int'(c));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_locked = 1; m_armed = 0; m_rst = 0; m_ctrl = '0; m_en = '0; m_flags = '0; m_cnt = 0;
    end else begin
      bit feed, run, hit_rst;
      logic [2:0] set, clr;
      feed = reg_wr && reg_addr == 3'd2 && reg_wdata == 32'hA5 + 32'h0 - 32'h4B && m_armed;
      feed = reg_wr && reg_addr == 3'd2 && reg_wdata == 32'h5A && m_armed;
      run = m_ctrl[0] && m_ctrl[1];
      set = '0; hit_rst = 0;
      if (feed) begin
        if (m_cnt < thr(m_ctrl[11:8])) set[1] = 1;
        m_cnt = 0;
      end else if (run && m_cnt != CMAX) begin
        m_cnt = m_cnt + 1;
        if (m_cnt == thr(m_ctrl[7:4])) set[0] = 1;
        if (m_cnt == thr(m_ctrl[15:12]) && m_en[2]) begin set[2] = 1; hit_rst = 1; end
      end
      clr = (reg_wr && reg_addr == 3'd4) ? reg_wdata[2:0] : 3'b0;
      m_flags = (m_flags & ~clr) | set;
      m_rst = hit_rst;
      if (reg_wr) m_armed = (reg_addr == 3'd2 && reg_wdata == 32'hA5);
      if (reg_wr && reg_addr == 3'd0 && !m_locked && reg_wdata[7:4] < PM &&
          reg_wdata[11:8] < PM && reg_wdata[15:12] < PM)
        m_ctrl = reg_wdata[15:0] & 16'hFFF3;
      if (reg_wr && reg_addr == 3'd1) m_en = reg_wdata[2:0];
      if (reg_wr && reg_addr == 3'd3 && reg_wdata == 32'hC3) m_locked = 0;
      else if (reg_wr && reg_addr == 3'd3 && reg_wdata == 32'h3C) m_locked = 1;
    end
  end

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return {16'h0, m_ctrl};
      3'd1: return {29'h0, m_en};
      3'd3: return {31'h0, m_locked};
      3'd4: return {29'h0, m_flags};
      default: return '0;
    endcase
  endfunction

  function automatic string rtag(input logic [2:0] a);
    case (a)
      3'd0: return "R3";
      3'd1: return "R11";
      3'd2: return "R7";
      3'd3: return "R2";
      3'd4: return "R10";
      default: return "R1";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // Cycle-level comparison against the model
  always @(negedge clk) begin
    #0.5;
    if (cmp_on) begin
      chk("R11 irq", {31'h0, irq}, {31'h0, |(m_flags & m_en)});
      chk("R9 rst_req", {31'h0, rst_req}, {31'h0, m_rst});
      chk(rtag(reg_addr), reg_rdata, m_read(reg_addr));
    end
  end

  // Tasks are entered in the negedge phase and leave in it.
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic feed_pair();
    wr(3'd2, 32'hA5);
    wr(3'd2, 32'h5A);
  endtask

  task automatic rd(input string tag, input logic [2:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic pin(input string tag, input logic got, input logic exp);
    #1;
    chk(tag, {31'h0, got}, {31'h0, exp});
  endtask

  task automatic rnd_op();
    int unsigned k;
    k = $urandom % 9;
    case (k)
      0: wr(3'd2, 32'hA5);
      1: wr(3'd2, 32'h5A);
      2, 3: feed_pair();
      4: wr(3'd3, ($urandom % 4 != 0) ? 32'hC3 : (($urandom % 2) ? 32'h3C : $urandom));
      5: wr(3'd0, {$urandom % 65536} & 32'h0 | {16'h0, 4'(5 + $urandom % 6), 4'(6 + $urandom % 5),
                   4'(6 + $urandom % 5), 2'($urandom), 1'b1, 1'($urandom % 8 != 0)});
      6: wr(3'd1, $urandom % 8);
      7: wr(3'($urandom % 8 == 0 ? 5 : 4), $urandom % 8);
      default: begin
        int n;
        n = $urandom % 24;
        for (int i = 0; i < n; i++) begin
          reg_addr = 3'($urandom % 8);
          @(negedge clk);
        end
      end
    endcase
    reg_addr = 3'($urandom % 8);
  endtask

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cmp_on = 1;
    // R1: reset state
    rd("R1 lock", 3'd3, 32'h1);
    rd("R1 ctrl", 3'd0, 32'h0);
    rd("R1 arm", 3'd1, 32'h0);
    rd("R1 flags", 3'd4, 32'h0);
    pin("R1 irq", irq, 1'b0);
    pin("R1 rst_req", rst_req, 1'b0);
    // R3: locked control ignores writes
    wr(3'd0, 32'h0000_7983);
    rd("R3 locked write", 3'd0, 32'h0);
    // R2: wrong key, then unlock
    wr(3'd3, 32'h55);
    rd("R2 bad key", 3'd3, 32'h1);
    wr(3'd3, 32'hC3);
    rd("R2 unlock", 3'd3, 32'h0);
    // R4: timeout code 10 is out of range
    wr(3'd0, 32'h0000_79A3);
    rd("R4 bad code", 3'd0, 32'h0);
    // R6: timeout after 16 clocks (code 8), wait 8 (code 9), reset 32 (code 7)
    wr(3'd1, 32'h1);
    wr(3'd0, 32'hFFFF_798F);
    rd("R3 ctrl readback", 3'd0, 32'h0000_7983);
    idle(15);
    rd("R6 before threshold", 3'd4, 32'h0);
    idle(1);
    rd("R6 at threshold", 3'd4, 32'h1);
    pin("R11 irq armed", irq, 1'b1);
    // R10: clear all
    wr(3'd4, 32'h7);
    rd("R10 cleared", 3'd4, 32'h0);
    pin("R11 irq low", irq, 1'b0);
    // R8: late feed no flag, early feed sets bit 1
    wr(3'd1, 32'h3);
    feed_pair();
    rd("R8 late feed", 3'd4, 32'h0);
    feed_pair();
    rd("R8 early feed", 3'd4, 32'h2);
    pin("R11 early irq", irq, 1'b1);
    // R7 + R9: aborted feed does not restart; reset pulse at 32
    wr(3'd4, 32'h7);
    wr(3'd1, 32'h5);
    feed_pair();
    idle(10);
    wr(3'd2, 32'hA5);
    wr(3'd1, 32'h5);
    wr(3'd2, 32'h5A);
    idle(18);
    pin("R7 abort no reset yet", rst_req, 1'b0);
    idle(1);
    pin("R9 reset pulse", rst_req, 1'b1);
    rd("R9 reset flag", 3'd4, 32'h7);
    idle(1);
    pin("R9 pulse one cycle", rst_req, 1'b0);
    // R5: timer disabled, nothing happens
    wr(3'd4, 32'h7);
    wr(3'd0, 32'h0000_7981);
    feed_pair();
    idle(100);
    rd("R5 stopped", 3'd4, 32'h0);
    pin("R5 no reset", rst_req, 1'b0);
    // R10: clear on the same edge as the timeout event, set wins
    wr(3'd0, 32'h0000_7983);
    feed_pair();
    rd("R8 feed right after start", 3'd4, 32'h2);
    idle(15);
    wr(3'd4, 32'h7);
    rd("R10 set wins", 3'd4, 32'h1);
    // R11: arm zero masks
    wr(3'd1, 32'h0);
    pin("R11 masked", irq, 1'b0);
    rd("R11 flag kept", 3'd4, 32'h1);
    // R2/R3: relock and write is ignored
    wr(3'd3, 32'h3C);
    rd("R2 relock", 3'd3, 32'h1);
    wr(3'd0, 32'h0);
    rd("R3 relocked write", 3'd0, 32'h0000_7983);
    // Random phase
    wr(3'd3, 32'hC3);
    for (int i = 0; i < 2500; i++) rnd_op();
    idle(2);
    cmp_on = 0;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule